// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which input channel an external converter samples next and which result slot the answer lands in. Sixteen slot control words each hold an input channel number and a last-in-run marker. A run begins at a programmed slot index. The run may be a single conversion, a walk through consecutive slots up to the marked slot, one slot converted again and again, or the marked walk repeated from the start slot.

A run begins on a trigger, but only while conversions are enabled. A trigger is either a rising edge on the hardware trigger pin or a one-cycle software start strobe. The software strobe may arrive in the same cycle that the enable is raised. When the converter reports completion, the block stores the result zero-extended into the addressed slot and sets that slot's flag in the same cycle. If the flag was still set, a sticky overflow flag is raised. The block then moves on. With auto-continue off, each following conversion waits for a fresh trigger. With it on, the next conversion is issued as soon as the previous one completes.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy, the start strobe, every slot flag and the overflow flag are 0, and every result slot reads 0.
- R2: While enable is low and the block is idle, triggers (a rising edge on `trig` or a `sw_start` cycle) issue no conversion.
- R3: Mode 2'b00 converts the start slot once, using that slot's channel, and busy is low by the cycle in which the converter's done is accepted.
- R4: A completed result is stored zero-extended in the low 12 bits of the current slot, and that slot's flag is set on the same clock edge.
- R5: Mode 2'b01 advances the slot index by one, modulo 16, after each conversion, and ends after converting the slot whose last-in-run marker is set.
- R6: Mode 2'b10 converts the same slot repeatedly while enable is high; clearing enable ends the run after the conversion in progress.
- R7: Mode 2'b11 returns to the start slot after the marked slot; clearing enable ends the run after the marked slot of the pass in progress.
- R8: With auto-continue clear, each conversion after the first waits for a new trigger, and busy stays high while waiting.
- R9: With auto-continue set, the next conversion of a sequence or repeat mode starts without any further trigger.
- R10: Storing into a slot whose flag is set raises the overflow flag, which stays set until `ovf_clr`; `flag_clr` bits clear the matching slot flags.
- R11: `sw_start` asserted in the same cycle that enable rises starts a run.
- R12: Triggers that arrive while a conversion is in progress start no extra conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Conversion enable |
| sw_start | input | 1 | Software start strobe, one request per high cycle |
| trig | input | 1 | Hardware trigger, acts on its rising edge |
| cfg_mode | input | 2 | Run mode: 00 once, 01 sequence, 10 repeat one, 11 repeat sequence |
| cfg_start | input | 4 | Start slot index |
| cfg_multi | input | 1 | Auto-continue from completion |
| ctl_we | input | 1 | Slot control word write strobe |
| ctl_idx | input | 4 | Slot control word index |
| ctl_eos | input | 1 | Last-in-run marker to write |
| ctl_chan | input | 4 | Channel number to write |
| conv_start | output | 1 | One-cycle request to the converter |
| conv_chan | output | 4 | Channel for the current slot |
| conv_slot | output | 4 | Current slot index |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 12 | Converter result |
| rd_idx | input | 4 | Result slot read index |
| rd_data | output | 16 | Result slot contents |
| flag_clr | input | 16 | Per-slot flag clear |
| ovf_clr | input | 1 | Overflow flag clear |
| slot_flags | output | 16 | Per-slot result-ready flags |
| ovf | output | 1 | Overflow flag |
| busy | output | 1 | High while a run is active |

## Verification
The bench builds the block with its default parameters: 16 slots, 4-bit channels, 12-bit results and 16-bit slots. With these values, a sequence starting at slot 14 crosses the 15-to-0 wrap within four conversions. The four zero bits above each result are visible on the read port. The bench's converter model answers three cycles after each request. This leaves room to inject triggers in the middle of a conversion and to drop the enable partway through a repeat run.

// File: rtl/seq_pkg.sv
// Package: shared types for the conversion sequencer.
// Assumes 2-bit mode encodings fixed by the control interface.
package seq_pkg;
    typedef enum logic [1:0] {
        MODE_ONCE    = 2'b00,
        MODE_SEQ     = 2'b01,
        MODE_RPT_ONE = 2'b10,
        MODE_RPT_SEQ = 2'b11
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_CONV = 2'b10
    } seq_state_e;
endpackage

// File: rtl/seq_slot_ctl.sv
// Slot control words: one channel number and one last-in-run marker per slot.
// Assumes a single write port and one combinational read port.
module seq_slot_ctl #(
    parameter int SLOTS = 16,
    parameter int IDX_W = 4,
    parameter int CH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_eos,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_eos,
    output logic [CH_W-1:0]  rd_chan
);
    logic [CH_W-1:0] chan_q [SLOTS];
    logic [SLOTS-1:0] eos_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Hold one slot's control word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_q[g] <= '0;
                eos_q[g]  <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                chan_q[g] <= wr_chan;
                eos_q[g]  <= wr_eos;
            end
        end
    end

    // Present the addressed slot's word.
    always_comb begin
        rd_chan = chan_q[rd_idx];
        rd_eos  = eos_q[rd_idx];
    end
endmodule

// File: rtl/seq_result_mem.sv
// Result slots with per-slot ready flags and a sticky overflow flag.
// Assumes at most one store per cycle; a store wins over a flag clear.
module seq_result_mem #(
    parameter int SLOTS = 16,
    parameter int IDX_W = 4,
    parameter int RES_W = 12,
    parameter int MEM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RES_W-1:0] wr_res,
    input  logic [SLOTS-1:0] flag_clr,
    input  logic             ovf_clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [MEM_W-1:0] rd_data,
    output logic [SLOTS-1:0] flags,
    output logic             ovf
);
    logic [MEM_W-1:0] mem_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Store the result and update the flag of one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
                flags[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                mem_q[g] <= MEM_W'(wr_res);
                flags[g] <= 1'b1;
            end else if (flag_clr[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

    // Sticky overflow on a store into a slot that is still flagged.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ovf <= 1'b0;
        else if (wr_en && flags[wr_idx])  ovf <= 1'b1;
        else if (ovf_clr)                 ovf <= 1'b0;
    end

    assign rd_data = mem_q[rd_idx];

    // R4: the stored slot is flagged after the store edge.
    a_r4_flag_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags[$past(wr_idx)]);
    // R10: storing over a flagged slot raises overflow.
    a_r10_ovf_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && flags[wr_idx]) |=> ovf);
    // R10: overflow is held until cleared.
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/seq_fsm.sv
// Run controller: issues conversion requests and walks the slot index by mode.
// Assumes trig_evt is already one cycle per trigger and the converter answers
// each request with exactly one done pulse.
module seq_fsm
    import seq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_mode_e        mode,
    input  logic [IDX_W-1:0] start_slot,
    input  logic             multi,
    input  logic             enable,
    input  logic             trig_evt,
    input  logic             conv_done,
    input  logic             slot_eos,
    output logic [IDX_W-1:0] idx,
    output logic             conv_start,
    output logic             store_en,
    output logic             busy
);
    seq_state_e       state;
    logic             stop;
    logic [IDX_W-1:0] idx_inc;
    logic [IDX_W-1:0] idx_nxt;

    // Modulo-SLOTS increment of the slot index.
    always_comb begin
        idx_inc = (idx == IDX_W'(SLOTS - 1)) ? '0 : idx + 1'b1;
    end

    // Decide on completion whether the run ends and which slot follows.
    always_comb begin
        stop    = 1'b1;
        idx_nxt = idx;
        unique case (mode)
            MODE_ONCE:    stop = 1'b1;
            MODE_SEQ:     begin stop = slot_eos; idx_nxt = idx_inc; end
            MODE_RPT_ONE: begin stop = !enable;  idx_nxt = idx;     end
            MODE_RPT_SEQ: begin
                stop    = slot_eos && !enable;
                idx_nxt = slot_eos ? start_slot : idx_inc;
            end
            default:      stop = 1'b1;
        endcase
    end

    // State, slot index and request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            idx        <= '0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            unique case (state)
                ST_IDLE: if (enable && trig_evt) begin
                    idx        <= start_slot;
                    state      <= ST_CONV;
                    conv_start <= 1'b1;
                end
                ST_WAIT: if (trig_evt) begin
                    state      <= ST_CONV;
                    conv_start <= 1'b1;
                end
                ST_CONV: if (conv_done) begin
                    if (stop) begin
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx_nxt;
                        if (multi) begin
                            conv_start <= 1'b1;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign store_en = (state == ST_CONV) && conv_done;
    assign busy     = (state != ST_IDLE);

    // R2: no request while idle and disabled.
    a_r2_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> !conv_start);
    // R3: a single conversion leaves the block idle.
    a_r3_once_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done && mode == MODE_ONCE) |=> !busy);
    // R5: the marked slot ends a sequence run.
    a_r5_seq_eos_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done && mode == MODE_SEQ && slot_eos) |=> !busy);
    // R6: repeat-one keeps the slot index.
    a_r6_same_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done && mode == MODE_RPT_ONE) |=> (idx == $past(idx)));
    // R8: a waiting run holds busy and issues nothing without a trigger.
    a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !trig_evt) |=> (busy && !conv_start));
    // R9: auto-continue restarts a sequence that has not reached its marker.
    a_r9_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done && multi && mode == MODE_SEQ && !slot_eos) |=> conv_start);
    // R12: nothing is requested while a conversion is pending.
    a_r12_no_start_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && !conv_done) |=> !conv_start);
endmodule

// File: rtl/conv_sequencer.sv
// Top of the conversion sequencer: trigger edge detection, slot control
// words, run controller and result slots.
// Assumes an external converter that answers conv_start with one conv_done.
module conv_sequencer
    import seq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int CH_W  = 4,
    parameter int RES_W = 12,
    parameter int MEM_W = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sw_start,
    input  logic             trig,
    input  logic [1:0]       cfg_mode,
    input  logic [IDX_W-1:0] cfg_start,
    input  logic             cfg_multi,
    input  logic             ctl_we,
    input  logic [IDX_W-1:0] ctl_idx,
    input  logic             ctl_eos,
    input  logic [CH_W-1:0]  ctl_chan,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic [IDX_W-1:0] conv_slot,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [MEM_W-1:0] rd_data,
    input  logic [SLOTS-1:0] flag_clr,
    input  logic             ovf_clr,
    output logic [SLOTS-1:0] slot_flags,
    output logic             ovf,
    output logic             busy
);
    logic trig_q;
    logic trig_evt;
    logic slot_eos;
    logic store_en;

    // Remember the trigger level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    assign trig_evt = sw_start || (trig && !trig_q);

    seq_slot_ctl #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CH_W(CH_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_we),
        .wr_idx  (ctl_idx),
        .wr_eos  (ctl_eos),
        .wr_chan (ctl_chan),
        .rd_idx  (conv_slot),
        .rd_eos  (slot_eos),
        .rd_chan (conv_chan)
    );

    seq_fsm #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (seq_mode_e'(cfg_mode)),
        .start_slot (cfg_start),
        .multi      (cfg_multi),
        .enable     (enable),
        .trig_evt   (trig_evt),
        .conv_done  (conv_done),
        .slot_eos   (slot_eos),
        .idx        (conv_slot),
        .conv_start (conv_start),
        .store_en   (store_en),
        .busy       (busy)
    );

    seq_result_mem #(.SLOTS(SLOTS), .IDX_W(IDX_W), .RES_W(RES_W), .MEM_W(MEM_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_en),
        .wr_idx   (conv_slot),
        .wr_res   (conv_result),
        .flag_clr (flag_clr),
        .ovf_clr  (ovf_clr),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .flags    (slot_flags),
        .ovf      (ovf)
    );

    // R1/R3: a request is only ever issued inside an active run.
    a_r3_start_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);
endmodule

// File: tb/sim_conv_sequencer.sv
// Directed bench for conv_sequencer with a fixed-latency converter model.
module sim_conv_sequencer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, sw_start = 1'b0, trig = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [3:0]  cfg_start = 4'd0;
    logic        cfg_multi = 1'b0;
    logic        ctl_we = 1'b0;
    logic [3:0]  ctl_idx = 4'd0;
    logic        ctl_eos = 1'b0;
    logic [3:0]  ctl_chan = 4'd0;
    logic        conv_start;
    logic [3:0]  conv_chan, conv_slot;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = 12'd0;
    logic [3:0]  rd_idx = 4'd0;
    logic [15:0] rd_data;
    logic [15:0] flag_clr = 16'd0;
    logic        ovf_clr = 1'b0;
    logic [15:0] slot_flags;
    logic        ovf, busy;

    int checks = 0;
    int errors = 0;
    int n_starts = 0;
    logic [3:0] log_slot [64];
    logic [3:0] log_chan [64];

    always #2 clk = ~clk;

    conv_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sw_start(sw_start), .trig(trig),
        .cfg_mode(cfg_mode), .cfg_start(cfg_start), .cfg_multi(cfg_multi),
        .ctl_we(ctl_we), .ctl_idx(ctl_idx), .ctl_eos(ctl_eos), .ctl_chan(ctl_chan),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_slot(conv_slot),
        .conv_done(conv_done), .conv_result(conv_result), .rd_idx(rd_idx),
        .rd_data(rd_data), .flag_clr(flag_clr), .ovf_clr(ovf_clr),
        .slot_flags(slot_flags), .ovf(ovf), .busy(busy)
    );

    function automatic logic [3:0] ch_of(input int s);
        return 4'((s * 5 + 3) % 16);
    endfunction

    function automatic logic [11:0] res_of(input int s);
        return {ch_of(s), 4'(s), 4'h5};
    endfunction

    // Converter model: answers each request LAT cycles later.
    initial begin
        int cnt = 0;
        logic [3:0] sl = 4'd0;
        logic [3:0] ch = 4'd0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (cnt != 0) begin
                cnt--;
                if (cnt == 0) begin
                    conv_done   = 1'b1;
                    conv_result = {ch, sl, 4'h5};
                end
            end
            if (conv_start) begin
                cnt = LAT;
                sl = conv_slot;
                ch = conv_chan;
                if (n_starts < 64) begin
                    log_slot[n_starts] = sl;
                    log_chan[n_starts] = ch;
                end
                n_starts++;
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_slot(input int s, input logic eos);
        ctl_we = 1'b1; ctl_idx = 4'(s); ctl_eos = eos; ctl_chan = ch_of(s);
        step();
        ctl_we = 1'b0;
    endtask

    task automatic clear_all();
        flag_clr = '1; ovf_clr = 1'b1;
        step();
        flag_clr = '0; ovf_clr = 1'b0;
        n_starts = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) step();
    endtask

    task automatic pulse_trig();
        trig = 1'b1; step(); trig = 1'b0; step();
    endtask

    task automatic t_reset();
        for (int s = 0; s < 16; s++) begin
            rd_idx = 4'(s); #1;
            chk("R1 slot zero", rd_data, 16'h0);
        end
        chk("R1 busy", busy, 0);
        chk("R1 flags", slot_flags, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 conv_start", conv_start, 0);
    endtask

    task automatic t_disabled();
        enable = 1'b0; cfg_mode = 2'b00;
        pulse_trig();
        sw_start = 1'b1; step(); sw_start = 1'b0;
        step(10);
        chk("R2 no conversion", n_starts, 0);
        chk("R2 not busy", busy, 0);
    endtask

    task automatic t_once();
        cfg_mode = 2'b00; cfg_start = 4'd6; cfg_multi = 1'b1; rd_idx = 4'd6;
        enable = 1'b1; sw_start = 1'b1;
        step();
        sw_start = 1'b0;
        chk("R11 start with enable", busy, 1);
        for (int i = 0; i < 50 && !conv_done; i++) step();
        chk("R3 busy low at done", busy, 0);
        chk("R4 flag at done", slot_flags, 32'h0040);
        chk("R4 zero-extended", rd_data, {4'h0, res_of(6)});
        step(10);
        chk("R3 one conversion", n_starts, 1);
        chk("R3 slot", log_slot[0], 6);
        chk("R3 channel", log_chan[0], ch_of(6));
        clear_all();
    endtask

    task automatic t_seq_wrap();
        write_slot(1, 1'b1);
        cfg_mode = 2'b01; cfg_start = 4'd14; cfg_multi = 1'b1; enable = 1'b1;
        pulse_trig();
        wait_idle();
        chk("R9 R5 count", n_starts, 4);
        chk("R5 slot a", log_slot[0], 14);
        chk("R5 slot b", log_slot[1], 15);
        chk("R5 wrap", log_slot[2], 0);
        chk("R5 eos", log_slot[3], 1);
        chk("R5 flags", slot_flags, 32'hC003);
        rd_idx = 4'd0; #1;
        chk("R4 slot0 data", rd_data, {4'h0, res_of(0)});
        write_slot(1, 1'b0);
        clear_all();
    endtask

    task automatic t_seq_manual();
        write_slot(5, 1'b1);
        cfg_mode = 2'b01; cfg_start = 4'd3; cfg_multi = 1'b0; enable = 1'b1;
        pulse_trig();
        step(12);
        chk("R8 one per trigger", n_starts, 1);
        chk("R8 busy while waiting", busy, 1);
        sw_start = 1'b1; step(); sw_start = 1'b0;
        step(12);
        chk("R8 second", n_starts, 2);
        chk("R8 second slot", log_slot[1], 4);
        pulse_trig();
        wait_idle();
        chk("R8 third", n_starts, 3);
        chk("R5 stop at eos", log_slot[2], 5);
        write_slot(5, 1'b0);
        clear_all();
    endtask

    task automatic t_rpt_one();
        int n_end;
        cfg_mode = 2'b10; cfg_start = 4'd9; cfg_multi = 1'b1; enable = 1'b1;
        sw_start = 1'b1; step(); sw_start = 1'b0;
        for (int i = 0; i < 100 && n_starts < 3; i++) step();
        enable = 1'b0;
        wait_idle();
        n_end = n_starts;
        chk("R6 stops after current", n_end, 3);
        for (int k = 0; k < 3; k++) chk("R6 same slot", log_slot[k], 9);
        step(20);
        chk("R6 no restart", n_starts, n_end);
        chk("R10 overflow on rewrite", ovf, 1);
        clear_all();
    endtask

    task automatic t_rpt_seq();
        write_slot(4, 1'b1);
        cfg_mode = 2'b11; cfg_start = 4'd2; cfg_multi = 1'b1; enable = 1'b1;
        pulse_trig();
        for (int i = 0; i < 100 && n_starts < 5; i++) step();
        enable = 1'b0;
        wait_idle();
        chk("R7 count", n_starts, 6);
        chk("R7 wrap to start", log_slot[3], 2);
        chk("R7 pass two", log_slot[4], 3);
        chk("R7 ends at eos", log_slot[5], 4);
        write_slot(4, 1'b0);
        clear_all();
    endtask

    task automatic t_overflow();
        cfg_mode = 2'b00; cfg_start = 4'd0; enable = 1'b1;
        pulse_trig(); wait_idle();
        chk("R10 no ovf first", ovf, 0);
        pulse_trig(); wait_idle();
        chk("R10 ovf second", ovf, 1);
        step(3);
        chk("R10 ovf sticky", ovf, 1);
        flag_clr = 16'h0001; ovf_clr = 1'b1; step(); flag_clr = '0; ovf_clr = 1'b0;
        chk("R10 ovf cleared", ovf, 0);
        chk("R10 flag cleared", slot_flags, 0);
        clear_all();
    endtask

    task automatic t_busy_ignore();
        cfg_mode = 2'b00; cfg_start = 4'd7; enable = 1'b1;
        pulse_trig();
        sw_start = 1'b1; step(); sw_start = 1'b0;
        wait_idle();
        step(10);
        chk("R12 one conversion", n_starts, 1);
        clear_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        for (int s = 0; s < 16; s++) write_slot(s, 1'b0);
        t_disabled();
        t_once();
        t_seq_wrap();
        t_seq_manual();
        t_rpt_one();
        t_rpt_seq();
        t_overflow();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule